// File: doc/BRIEF.md
# SPI Slave Front End for a Three-Bank Byte RAM

This block lets an external host read and write an on-chip byte RAM over a four-wire serial link. The RAM holds three banks: a transmit FIFO bank, a receive FIFO bank and a security bank. The host lowers chip select and sends a command byte. If that byte selects RAM, it carries a 7-bit offset within a bank. A bank byte follows, giving the bank number and a mode bit. After that, data bytes stream in both directions, and the offset steps by one after each byte. The transfer continues until chip select goes high.

There are two modes. In the default mode the block writes each incoming byte into RAM and, during the same byte time, shifts out the value that was stored at that location before the write. In read-only mode it shifts out the stored bytes and discards whatever arrives on the serial input. A command byte that selects something other than RAM is reported on a one-cycle output. The rest of that transaction is then ignored.

The serial pins are sampled in the system clock domain, and each SCLK half period must last at least 6 clock cycles. The RAM sits outside the block and has a synchronous port with a read latency of one cycle. The flat RAM address is `{bank[1:0], offset[6:0]}`.

Top module: `spi_ram_slave`

## Requirements
- R1: In the command byte (MSB first), bit 7 = 1 selects a RAM access and bits 6:0 give the offset. If bit 7 = 0, `reg_access` is high for exactly one clock after the eighth rising SCLK edge, and every later byte in that transaction causes no RAM write and reads back 0x00.
- R2: In the second byte of a RAM access, bits 7:6 give the bank and bit 5 gives the mode (0 = read-while-write, 1 = read-only). Bits 4:0 have no effect.
- R3: In read-while-write mode, each complete data byte is written to `ram_addr = {bank, offset}`. During that same byte, SO shifts out the value the location held beforehand, MSB first. There is at most one write per clock.
- R4: In read-only mode, SO shifts out the stored bytes and no RAM write takes place.
- R5: After each data byte the offset advances by one. It wraps from 127 to 0 and stays in the same bank.
- R6: Bank 3, and offsets 112 to 127 of bank 2, are never written, and they read back 0x00.
- R7: SO changes only after a falling SCLK edge. SO is 0x00 during the command byte and the bank byte.
- R8: While CSn is high, `so` and `so_oe` are low. Raising CSn in the middle of a byte discards that partial byte and resets the parser.
- R9: After reset, `so`, `ram_en`, `ram_we` and `reg_access` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host (mode 0) |
| si | input | 1 | Serial data from the host |
| csn | input | 1 | Active-low chip select |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | High while SO should be driven |
| reg_access | output | 1 | One-cycle pulse for a non-RAM command byte |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM address, bank in bits 8:7 |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after a read |

## Verification
The assertions check several properties on every cycle:
- SO stays quiet while chip select is high.
- SO changes only after a falling SCLK edge.
- Writes are never back to back.
- No write lands in bank 3 or in the unused top of the security bank.
- The non-RAM flag is a single-cycle pulse.

Other behaviour can only be shown by the bench scenarios: the byte values returned in read-while-write mode, the silence of read-only mode, offset wrap within a bank, and the loss of a byte cut short by chip select. For these, the bench compares every SO byte and every RAM write against its own model of the memory.

// File: rtl/spi_ram_pkg.sv
package spi_ram_pkg;

    localparam int BANK_W    = 2;
    localparam int OFFS_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int RADDR_W   = BANK_W + OFFS_W;
    localparam int SEC_BANK  = 2;
    localparam int SEC_DEPTH = 112;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_BANK,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFFS_W-1:0] offs;
    } ram_loc_t;

    function automatic logic loc_ok(ram_loc_t a);
        if (a.bank == {BANK_W{1'b1}}) return 1'b0;
        if (a.bank == BANK_W'(SEC_BANK) && a.offs >= OFFS_W'(SEC_DEPTH)) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              si,
    input  logic              csn,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              so_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              so_q;
    logic              rise, fall;

    assign rise      = ~csn & sclk & ~sclk_q;
    assign fall      = ~csn & ~sclk & sclk_q;
    assign byte_done = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sh[BYTE_W-2:0], si};
    assign so_bit    = so_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            so_q    <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (csn) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
                so_q    <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= rx_byte;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (fall) begin
                    if (bit_cnt == '0) begin
                        so_q  <= tx_en ? tx_byte[BYTE_W-1] : 1'b0;
                        tx_sh <= tx_en ? {tx_byte[BYTE_W-2:0], 1'b0} : '0;
                    end else begin
                        so_q  <= tx_sh[BYTE_W-1];
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_ram_ctrl.sv
module spi_ram_ctrl
    import spi_ram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               csn,
    input  logic               byte_done,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic               tx_en,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               reg_access,
    output logic               ram_en,
    output logic               ram_we,
    output logic [RADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0]  ram_wdata,
    input  logic [BYTE_W-1:0]  ram_rdata
);
    phase_t            phase;
    ram_loc_t          cur, wr_loc, rd_loc, nxt;
    logic              read_only;
    logic              req_wr, req_rd, rd_pend, reg_q;
    logic [BYTE_W-1:0] wr_data, tx_buf;

    assign nxt        = '{bank: cur.bank, offs: cur.offs + 1'b1};
    assign tx_en      = (phase == PH_DATA);
    assign tx_byte    = tx_buf;
    assign reg_access = reg_q;
    assign ram_en     = req_wr | req_rd;
    assign ram_we     = req_wr;
    assign ram_addr   = req_wr ? wr_loc : rd_loc;
    assign ram_wdata  = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            cur       <= '0;
            wr_loc    <= '0;
            rd_loc    <= '0;
            read_only <= 1'b0;
            req_wr    <= 1'b0;
            req_rd    <= 1'b0;
            rd_pend   <= 1'b0;
            reg_q     <= 1'b0;
            wr_data   <= '0;
            tx_buf    <= '0;
        end else begin
            reg_q   <= 1'b0;
            rd_pend <= ram_en & ~ram_we;
            if (rd_pend) tx_buf <= ram_rdata;
            if (req_wr)      req_wr <= 1'b0;
            else if (req_rd) req_rd <= 1'b0;

            if (csn) begin
                phase <= PH_CMD;
            end else if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        if (rx_byte[BYTE_W-1]) begin
                            cur.offs <= rx_byte[OFFS_W-1:0];
                            phase    <= PH_BANK;
                        end else begin
                            reg_q <= 1'b1;
                            phase <= PH_SKIP;
                        end
                    end
                    PH_BANK: begin
                        cur.bank  <= rx_byte[BYTE_W-1 -: BANK_W];
                        read_only <= rx_byte[BYTE_W-1-BANK_W];
                        phase     <= PH_DATA;
                        rd_loc    <= '{bank: rx_byte[BYTE_W-1 -: BANK_W], offs: cur.offs};
                        if (loc_ok('{bank: rx_byte[BYTE_W-1 -: BANK_W], offs: cur.offs}))
                            req_rd <= 1'b1;
                        else
                            tx_buf <= '0;
                    end
                    PH_DATA: begin
                        if (!read_only && loc_ok(cur)) begin
                            req_wr  <= 1'b1;
                            wr_loc  <= cur;
                            wr_data <= rx_byte;
                        end
                        cur    <= nxt;
                        rd_loc <= nxt;
                        if (loc_ok(nxt)) req_rd <= 1'b1;
                        else             tx_buf <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_ram_slave.sv
module spi_ram_slave
    import spi_ram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk,
    input  logic               si,
    input  logic               csn,
    output logic               so,
    output logic               so_oe,
    output logic               reg_access,
    output logic               ram_en,
    output logic               ram_we,
    output logic [RADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0]  ram_wdata,
    input  logic [BYTE_W-1:0]  ram_rdata
);
    logic              byte_done, tx_en, so_bit;
    logic [BYTE_W-1:0] rx_byte, tx_byte;

    spi_bit_engine u_bits (
        .clk(clk), .rst(rst), .sclk(sclk), .si(si), .csn(csn),
        .tx_en(tx_en), .tx_byte(tx_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .so_bit(so_bit)
    );

    spi_ram_ctrl u_ctrl (
        .clk(clk), .rst(rst), .csn(csn),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .tx_en(tx_en), .tx_byte(tx_byte), .reg_access(reg_access),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    assign so    = so_bit & ~csn;
    assign so_oe = ~csn;

endmodule

// File: rtl/spi_ram_slave_chk.sv
module spi_ram_slave_chk
    import spi_ram_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sclk,
    input logic               csn,
    input logic               so,
    input logic               reg_access,
    input logic               ram_we,
    input logic [RADDR_W-1:0] ram_addr
);
    AST_SO_QUIET: assert property (@(posedge clk) disable iff (rst) csn |-> !so); // R8
    AST_REG_PULSE: assert property (@(posedge clk) disable iff (rst) reg_access |=> !reg_access); // R1
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst) ram_we |=> !ram_we); // R3
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr[RADDR_W-1 -: BANK_W] != 2'd3) &&
                   !(ram_addr[RADDR_W-1 -: BANK_W] == 2'd2 && ram_addr[OFFS_W-1:0] >= OFFS_W'(SEC_DEPTH))); // R6
    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!csn && $past(!csn) && so != $past(so)) |-> (!$past(sclk) && $past(sclk, 2))); // R7
endmodule

bind spi_ram_slave spi_ram_slave_chk chk (.*);

// File: tb/spi_ram_slave_test.sv
`timescale 1ns/1ps
module spi_ram_slave_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       si = 1'b0;
    logic       csn = 1'b1;
    logic       so, so_oe, reg_access, ram_en, ram_we;
    logic [8:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata = 8'h00;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int reg_pulses = 0;

    logic [7:0]  mem [0:511];
    logic [7:0]  ref_mem [0:511];
    logic [16:0] exp_wr [$];

    spi_ram_slave uut (
        .clk(clk), .rst(rst), .sclk(sclk), .si(si), .csn(csn),
        .so(so), .so_oe(so_oe), .reg_access(reg_access),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end
        if (reg_access) reg_pulses <= reg_pulses + 1;
        cycles <= cycles + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-clock write comparison against the model's expected write stream (R3, R4, R6)
    always @(negedge clk) begin
        if (!rst && ram_we) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R4 unexpected write", {ram_addr, ram_wdata}, 0);
            end else begin
                logic [16:0] e;
                e = exp_wr.pop_front();
                check({ram_addr, ram_wdata} == e, "R3 write addr/data", {ram_addr, ram_wdata}, e);
            end
        end
        if (!rst && csn) begin
            if (so !== 1'b0 || so_oe !== 1'b0) check(1'b0, "R8 SO quiet", {so, so_oe}, 0);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 0);
            finish_run();
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_clk(HALF);
            rx[i] = so;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(4 * HALF);
    endtask

    function automatic bit valid_loc(input logic [1:0] b, input logic [6:0] o);
        return !(b == 2'd3 || (b == 2'd2 && o >= 7'd112));
    endfunction

    task automatic ram_txn(input logic [1:0] b, input logic [6:0] o, input bit ro,
                           input int n, input logic [7:0] base, input string req);
        logic [7:0] rx, tx, exp;
        logic [6:0] off;
        cs_low();
        xfer({1'b1, o}, rx);
        check(rx == 8'h00, "R7 SO zero in command byte", rx, 0);
        xfer({b, ro, 5'b10101}, rx);          // low bits junk: R2
        check(rx == 8'h00, "R7 SO zero in bank byte", rx, 0);
        off = o;
        for (int k = 0; k < n; k++) begin
            tx  = base + 8'(k * 13);
            exp = valid_loc(b, off) ? ref_mem[{b, off}] : 8'h00;
            if (!ro && valid_loc(b, off)) begin
                exp_wr.push_back({b, off, tx});
                ref_mem[{b, off}] = tx;
            end
            xfer(tx, rx);
            check(rx == exp, req, rx, exp);
            off = off + 7'd1;                  // R5 wrap within bank
        end
        cs_high();
    endtask

    initial begin
        logic [7:0] rx;
        int p0;
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        check(so == 0 && ram_en == 0 && ram_we == 0 && reg_access == 0, "R9 reset outputs",
              {so, ram_en, ram_we, reg_access}, 0);

        ram_txn(2'd0, 7'd10, 1'b0, 4, 8'hA1, "R3 read-while-write old data");
        ram_txn(2'd0, 7'd10, 1'b1, 4, 8'h55, "R4 read-only returns stored data");
        ram_txn(2'd1, 7'd126, 1'b0, 4, 8'h3C, "R5 offset wrap 127 to 0");
        ram_txn(2'd1, 7'd126, 1'b1, 4, 8'h00, "R5 wrapped data read back");
        ram_txn(2'd2, 7'd110, 1'b0, 4, 8'hC7, "R6 security bank limit");
        ram_txn(2'd3, 7'd0, 1'b0, 2, 8'h99, "R6 bank 3 reads zero");
        ram_txn(2'd2, 7'd127, 1'b0, 2, 8'h42, "R6 R5 security wrap");
        ram_txn(2'd2, 7'd0, 1'b1, 1, 8'h00, "R5 security offset 0 written");

        // R1: non-RAM command byte
        p0 = reg_pulses;
        cs_low();
        xfer(8'h15, rx);
        wait_clk(2);
        check(reg_pulses - p0 == 1, "R1 reg_access single pulse", reg_pulses - p0, 1);
        for (int k = 0; k < 3; k++) begin
            xfer(8'hE0 + 8'(k), rx);
            check(rx == 8'h00, "R1 bytes after non-RAM command ignored", rx, 0);
        end
        cs_high();
        check(reg_pulses - p0 == 1, "R1 no further pulses", reg_pulses - p0, 1);

        // R8: abort in the middle of a data byte
        cs_low();
        xfer({1'b1, 7'd40}, rx);
        xfer({2'd0, 1'b0, 5'd0}, rx);
        for (int i = 7; i >= 4; i--) begin
            si = 1'b1;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(2);
        csn = 1'b1;
        wait_clk(3);
        check(so == 0 && so_oe == 0, "R8 outputs quiet after abort", {so, so_oe}, 0);
        wait_clk(4 * HALF);
        ram_txn(2'd0, 7'd40, 1'b1, 1, 8'h00, "R8 partial byte not written");

        wait_clk(10);
        check(exp_wr.size() == 0, "R3 all expected writes seen", exp_wr.size(), 0);
        finish_run();
    end
endmodule